// File: doc/BRIEF.md
# Ramp-Compare Converter Counter Bank

This block is the digital back end of a single-slope (ramp-compare) converter that digitises a whole array of stored analog samples at once. One shared counter advances on every conversion clock while an external ramp rises. Each storage cell has its own comparator, which reaches the block as a digital input. The first time a comparator goes high, that cell copies the current counter value into its own code register. A cell whose comparator never switches gets the all-ones code when the counter saturates.

Before each conversion, software or a sequencer pulses the clear strobe. It then drives the active-low ramp control low for the length of the conversion window. At 2 GHz and 12 bits, the window is 4096 clocks, which is just over 2 us. A flag reports when every cell holds a code. A free-running divided clock lets the conversion-clock frequency be measured off chip. At 2 GHz and a divide ratio of 4096, this monitor clock runs at about 500 kHz.

Top module: `wadc_counter_bank`

## Requirements
- R1: A cycle with `clear_i` high sets the shared count to 0 on that edge, sets every code to 0, re-arms every cell and drops `done_o`. Clear takes priority over the ramp control.
- R2: While `ramp_ni` is low, the count rises by one per clock until it reaches all ones. While `ramp_ni` is high, the count holds. Because of this, a cell whose comparator rises on the k-th ramp-low clock after a clear stores k, however many ramp-high clocks came before.
- R3: A cell's comparator rises when it is sampled high at an edge after being sampled low at the previous edge. On such an edge, with the ramp low, an un-latched cell stores the count value present before that edge.
- R4: Once a cell has latched, further comparator edges in the same conversion leave its code unchanged.
- R5: Comparator edges while `ramp_ni` is high latch nothing: codes stay 0 and `done_o` stays low.
- R6: The count saturates at all ones (2^CODE_W-1). On the ramp-low edge at which the count equals all ones, every un-latched cell stores all ones as its overflow code.
- R7: `done_o` is high exactly when every cell has latched. That happens when all comparators have fired, or at saturation.
- R8: `mon_clk_o` is the conversion clock divided by 2^MON_DIV_LOG2, with 50% duty. It is 0 out of reset.
- R9: After reset, all codes are 0 and `done_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Conversion clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Clear strobe before each conversion |
| ramp_ni | input | 1 | Ramp control, low = ramp running, high = ramp held cleared |
| comp_i | input | N_CELLS | Comparator outputs, one per cell |
| code_o | output | N_CELLS*CODE_W | Latched codes, cell i at bits [i*CODE_W +: CODE_W] |
| done_o | output | 1 | All cells latched |
| mon_clk_o | output | 1 | Divided monitor clock |

## Verification
The bench builds the bank with 8 cells, 5-bit codes and a divide-by-8 monitor. This brings a full 32-step conversion window within a few dozen clocks. Every firing step from 0 through past saturation can then be swept for every cell, each sweep with and without a second, spurious comparator edge. The small divider makes the monitor period and duty cycle measurable in a short window. Expected codes are computed as the firing step clipped to all ones, and expected `done_o` is computed from the latest firing step.

// File: rtl/wadc_pkg.sv
package wadc_pkg;
  localparam int unsigned N_CELLS_DEF      = 256;
  localparam int unsigned CODE_W_DEF       = 12;
  localparam int unsigned MON_DIV_LOG2_DEF = 12;
endpackage

// File: rtl/wadc_ramp_counter.sv
module wadc_ramp_counter #(
  parameter int unsigned CODE_W = wadc_pkg::CODE_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              ramp_ni,
  output logic [CODE_W-1:0] cnt_o,
  output logic              sat_o
);
  localparam logic [CODE_W-1:0] CNT_MAX = {CODE_W{1'b1}};

  logic [CODE_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (clear_i)                    cnt_q <= '0;
    else if (!ramp_ni && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
  assign sat_o = (cnt_q == CNT_MAX);

  assert_clear_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> cnt_q == '0);
  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ramp_ni && !clear_i) |=> $stable(cnt_q));
  assert_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ramp_ni && !clear_i && cnt_q != CNT_MAX) |=> cnt_q == CODE_W'($past(cnt_q) + 1'b1));
  assert_sat_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && !clear_i) |=> cnt_q == CNT_MAX);
endmodule

// File: rtl/wadc_cell_latch.sv
module wadc_cell_latch #(
  parameter int unsigned CODE_W = wadc_pkg::CODE_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              arm_i,
  input  logic              sat_i,
  input  logic [CODE_W-1:0] cnt_i,
  input  logic              comp_i,
  output logic [CODE_W-1:0] code_o,
  output logic              hit_o
);
  logic              comp_q;
  logic              hit_q;
  logic [CODE_W-1:0] code_q;
  logic              rise;

  assign rise = comp_i & ~comp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) comp_q <= 1'b0;
    else         comp_q <= comp_i;
  end

  // overflow fill shares the latch path: at saturation cnt_i is all ones
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q  <= 1'b0;
      code_q <= '0;
    end else if (clear_i) begin
      hit_q  <= 1'b0;
      code_q <= '0;
    end else if (arm_i && !hit_q && (rise || sat_i)) begin
      hit_q  <= 1'b1;
      code_q <= cnt_i;
    end
  end

  assign code_o = code_q;
  assign hit_o  = hit_q;

  assert_latch_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hit_q) |-> code_q == $past(cnt_i));
  assert_keep_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_q && !clear_i) |=> $stable(code_q));
  assert_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!arm_i && !clear_i) |=> $stable(hit_q));
endmodule

// File: rtl/wadc_mon_div.sv
module wadc_mon_div #(
  parameter int unsigned MON_DIV_LOG2 = wadc_pkg::MON_DIV_LOG2_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic mon_clk_o
);
  logic [MON_DIV_LOG2-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_q + 1'b1;
  end

  assign mon_clk_o = div_q[MON_DIV_LOG2-1];

  assert_mon_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_q[MON_DIV_LOG2-2:0] != '0) |-> $stable(mon_clk_o));
endmodule

// File: rtl/wadc_counter_bank.sv
module wadc_counter_bank #(
  parameter int unsigned N_CELLS      = wadc_pkg::N_CELLS_DEF,
  parameter int unsigned CODE_W       = wadc_pkg::CODE_W_DEF,
  parameter int unsigned MON_DIV_LOG2 = wadc_pkg::MON_DIV_LOG2_DEF
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      clear_i,
  input  logic                      ramp_ni,
  input  logic [N_CELLS-1:0]        comp_i,
  output logic [N_CELLS*CODE_W-1:0] code_o,
  output logic                      done_o,
  output logic                      mon_clk_o
);
  logic [CODE_W-1:0]  cnt;
  logic               sat;
  logic [N_CELLS-1:0] hit;

  wadc_ramp_counter #(.CODE_W(CODE_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_i),
    .ramp_ni (ramp_ni),
    .cnt_o   (cnt),
    .sat_o   (sat)
  );

  for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
    wadc_cell_latch #(.CODE_W(CODE_W)) u_cell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clear_i (clear_i),
      .arm_i   (~ramp_ni),
      .sat_i   (sat),
      .cnt_i   (cnt),
      .comp_i  (comp_i[i]),
      .code_o  (code_o[i*CODE_W +: CODE_W]),
      .hit_o   (hit[i])
    );
  end

  assign done_o = &hit;

  wadc_mon_div #(.MON_DIV_LOG2(MON_DIV_LOG2)) u_mon (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mon_clk_o (mon_clk_o)
  );

  assert_sat_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sat && !ramp_ni && !clear_i) |=> done_o);
  assert_clear_done_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !done_o);
endmodule

// File: tb/sim_wadc_counter_bank.sv
`timescale 1ns/1ps
module sim_wadc_counter_bank;
  localparam int N   = 8;
  localparam int CW  = 5;
  localparam int DL  = 3;
  localparam int MAXC = (1 << CW) - 1;
  localparam int NSTEP = MAXC + 3;

  logic clk = 1'b0, rst_n = 1'b0, clear = 1'b0, ramp_n = 1'b1;
  logic [N-1:0] comp = '0;
  logic [N*CW-1:0] code;
  logic done, mon;

  int n_run = 0, n_fail = 0, cyc = 0;

  always #4 clk = ~clk;

  wadc_counter_bank #(.N_CELLS(N), .CODE_W(CW), .MON_DIV_LOG2(DL)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clear), .ramp_ni(ramp_n),
    .comp_i(comp), .code_o(code), .done_o(done), .mon_clk_o(mon)
  );

  always @(posedge clk) cyc++;

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    while (cyc < 150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
    finish_run();
  end

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int cell_code(input int i);
    return int'(code[i*CW +: CW]);
  endfunction

  // at a negedge on entry and exit
  task automatic step(input logic rn, input logic [N-1:0] c);
    ramp_n = rn; comp = c;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_clear();
    clear = 1'b1; ramp_n = 1'b1; comp = '0;
    @(posedge clk); @(negedge clk);
    clear = 1'b0;
  endtask

  // fire[i] < 0 : never; reedge: drop after the first rise and rise again
  task automatic run_conv(input int fire[N], input bit reedge, input string tag);
    int last;
    bit all;
    do_clear();
    for (int i = 0; i < N; i++) chk("R1 clear code", cell_code(i), 0);
    chk("R1 clear done", done, 0);
    all = 1'b1; last = 0;
    for (int i = 0; i < N; i++) begin
      if (fire[i] < 0 || fire[i] > MAXC) all = 1'b0;
      else if (fire[i] > last) last = fire[i];
    end
    for (int j = 0; j < NSTEP; j++) begin
      logic [N-1:0] c;
      int ed;
      for (int i = 0; i < N; i++) begin
        c[i] = (fire[i] >= 0) && (j >= fire[i]);
        if (reedge && (j == fire[i] + 1 || j == fire[i] + 2)) c[i] = 1'b0;
      end
      step(1'b0, c);
      ed = ((j >= MAXC) || (all && j >= last)) ? 1 : 0;
      chk({"R7 done ", tag}, done, ed);
    end
    for (int i = 0; i < N; i++) begin
      int e;
      e = (fire[i] < 0 || fire[i] > MAXC) ? MAXC : fire[i];
      chk(reedge ? {"R4 R3 code ", tag} : {"R3 R6 code ", tag}, cell_code(i), e);
    end
  endtask

  initial begin
    int f[N];
    int rise_at[$];
    int hi_len;
    logic prev;
    repeat (3) @(negedge clk);
    chk("R9 reset done", done, 0);
    for (int i = 0; i < N; i++) chk("R9 reset code", cell_code(i), 0);
    chk("R8 reset mon", mon, 0);
    rst_n = 1'b1;

    // R8: period and duty of monitor clock
    prev = mon; hi_len = 0;
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      if (mon && !prev) rise_at.push_back(k);
      if (mon) hi_len++;
      prev = mon;
    end
    chk("R8 mon rises", rise_at.size(), 64 >> DL);
    if (rise_at.size() >= 2) chk("R8 mon period", rise_at[1] - rise_at[0], 1 << DL);
    chk("R8 mon duty", hi_len, 32);

    // R5 and R2: edges while ramp held are ignored and the count does not move
    do_clear();
    for (int j = 0; j < 6; j++) step(1'b1, (j >= 2) ? 8'hFF : 8'h00);
    for (int i = 0; i < N; i++) chk("R5 held code", cell_code(i), 0);
    chk("R5 held done", done, 0);
    for (int j = 0; j < 6; j++) step(1'b0, (j >= 4) ? 8'hFF : 8'h00);
    for (int i = 0; i < N; i++) chk("R2 code after hold", cell_code(i), 4);
    chk("R7 done after hold", done, 1);

    // sweep every firing step across every cell, with and without re-edges
    for (int rr = 0; rr < 2; rr++) begin
      for (int s = 0; s < NSTEP; s++) begin
        for (int i = 0; i < N; i++) f[i] = (s + 5 * i) % (NSTEP + 1);
        run_conv(f, rr[0], "sweep");
      end
    end

    // odd cells never fire: overflow on those only
    for (int i = 0; i < N; i++) f[i] = i[0] ? -1 : 3 * i;
    run_conv(f, 1'b0, "R6 partial");
    // all at step 0 and all at the last unsaturated step
    for (int i = 0; i < N; i++) f[i] = 0;
    run_conv(f, 1'b1, "step0");
    for (int i = 0; i < N; i++) f[i] = MAXC;
    run_conv(f, 1'b0, "stepmax");

    finish_run();
  end
endmodule